// File: doc/BRIEF.md
# Compressed Branch and Jump Target Unit

This block works out where control goes next for a stream of 16-bit compressed instructions. Each cycle that `in_valid` is high it takes the instruction's address, its first halfword and (for the 32-bit absolute jump) its second halfword. It also takes the values of the operand register, the return-address register and the implicit test register. From these it decides whether control transfers and computes the destination address. It produces a return-address write for linking jumps and flags that a jump is followed by one delay-slot halfword.

Every jump has a delay slot. The unit tracks this and supplies, with each result, the base address that a PC-relative calculation in that instruction must use. For the instruction sitting in a jump's delay slot, that base is the jump's own address. For any other instruction it is the instruction's own address. The unit does not fetch, read the register file or execute the slot instruction. Results are registered and appear one cycle after the instruction is presented.

Top module: `cbj_unit`

## Requirements
- R1: Synchronous active-high reset clears `res_valid`, `br_taken`, `link_we`, `slot_req`, `illegal` and the pending-slot state.
- R2: Opcode `hw_first[15:11]` = 00100 is taken when `rx_val` is zero, and 00101 is taken when `rx_val` is non-zero. The target is `pc_in + 2 + (signext(hw_first[7:0]) << 2)`.
- R3: Opcode 01100 with `hw_first[10:8]` = 000 is taken when `test_val` is zero, and with 001 when it is non-zero. The target rule is the same as R2.
- R4: Opcode 00010 is always taken, with target `pc_in + 2 + (signext(hw_first[10:0]) << 1)`.
- R5: Opcode 00011 is a 32-bit absolute jump, always taken. Its target is assembled as follows: bits 31:26 from `pc_in + 4`, bits 25:21 from `hw_first[4:0]`, bits 20:16 from `hw_first[9:5]` and bits 15:0 from `hw_second`.
- R6: When `hw_first[10]` of the absolute jump is 1, bit 0 of the assembled target is inverted.
- R7: Opcode 11101 with `hw_first[4:0]` = 00000 is a register jump, always taken. Variant `hw_first[7:5]` selects the target: 000 gives `rx_val`, 001 gives `ra_val` and 010 gives `rx_val`.
- R8: The absolute jump and register-jump variant 010 raise `link_we`. The `link_val` is the return point past the delay slot: `pc_in + 6` for the absolute jump and `pc_in + 4` for the register jump. No other instruction raises `link_we`.
- R9: Every jump (R5, R7) raises `slot_req`; branches (R2–R4) never do.
- R10: The next valid instruction after a result with `slot_req` receives `slot_base` equal to that jump's `pc_in`, even across idle cycles. Every other instruction receives its own `pc_in`.
- R11: A register jump whose variant is 011–111 raises `illegal` and leaves `br_taken`, `slot_req` and `link_we` low.
- R12: Each instruction presented with `in_valid` high yields exactly one result, with `res_valid` high on the following cycle. While `res_valid` is low, `br_taken`, `slot_req`, `link_we` and `illegal` are low.
- R13: Any other encoding is not a control transfer. This covers opcode 01100 with another sub-code, opcode 11101 with a non-zero function field and all other opcodes. Such an instruction leaves `br_taken`, `slot_req`, `link_we` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| pc_in | input | ADDR_W | Address of the instruction |
| hw_first | input | 16 | First instruction halfword |
| hw_second | input | 16 | Second halfword (absolute jump only) |
| rx_val | input | ADDR_W | Value of the operand register |
| ra_val | input | ADDR_W | Value of the return-address register |
| test_val | input | ADDR_W | Value of the implicit test register |
| res_valid | output | 1 | Result for the previous cycle's instruction |
| br_taken | output | 1 | Control transfers |
| br_target | output | ADDR_W | Destination address |
| link_we | output | 1 | Write the return-address register |
| link_val | output | ADDR_W | Value to write on link |
| slot_req | output | 1 | One delay-slot halfword follows |
| slot_base | output | ADDR_W | Base for PC-relative work of this instruction |
| illegal | output | 1 | Unused register-jump variant |

## Verification
The pending-slot flag and the saved jump address are the only state that outlives one instruction. A flag stuck high shows up as a wrong `slot_base` on the very next non-slot instruction. A flag that clears early gives a wrong base to the slot instruction itself, one cycle after it is presented. Decode mistakes show up in the same result cycle as a wrong `br_taken`, `slot_req`, `link_we` or `illegal`. Field-assembly mistakes show up there as a wrong target bit. The stimulus therefore chains jumps into each other's slots and parks a pending slot across idle cycles.

// File: rtl/cbj_pkg.sv
package cbj_pkg;

  localparam logic [4:0] OP_BR_EQZ  = 5'b00100;
  localparam logic [4:0] OP_BR_NEZ  = 5'b00101;
  localparam logic [4:0] OP_GROUP8  = 5'b01100;
  localparam logic [4:0] OP_BR_ALL  = 5'b00010;
  localparam logic [4:0] OP_JMP_ABS = 5'b00011;
  localparam logic [4:0] OP_REGREG  = 5'b11101;

  typedef enum logic [2:0] {
    K_NONE,
    K_BR_REG,
    K_BR_TEST,
    K_BR_ALWAYS,
    K_JMP_ABS,
    K_JMP_REG
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  want_zero;
    logic  from_ra;
    logic  link;
    logic  xchg;
    logic  bad;
  } dec_t;

endpackage

// File: rtl/cbj_decode.sv
module cbj_decode
  import cbj_pkg::*;
(
  input  logic [15:0] hw0,
  output dec_t        dec
);

  always_comb begin
    dec = '0;
    dec.kind = K_NONE;
    case (hw0[15:11])
      OP_BR_EQZ: begin
        dec.kind      = K_BR_REG;
        dec.want_zero = 1'b1;
      end
      OP_BR_NEZ: begin
        dec.kind      = K_BR_REG;
        dec.want_zero = 1'b0;
      end
      OP_GROUP8: begin
        if (hw0[10:9] == 2'b00) begin
          dec.kind      = K_BR_TEST;
          dec.want_zero = ~hw0[8];
        end
      end
      OP_BR_ALL: dec.kind = K_BR_ALWAYS;
      OP_JMP_ABS: begin
        dec.kind = K_JMP_ABS;
        dec.link = 1'b1;
        dec.xchg = hw0[10];
      end
      OP_REGREG: begin
        if (hw0[4:0] == 5'b00000) begin
          case (hw0[7:5])
            3'b000: dec.kind = K_JMP_REG;
            3'b001: begin
              dec.kind    = K_JMP_REG;
              dec.from_ra = 1'b1;
            end
            3'b010: begin
              dec.kind = K_JMP_REG;
              dec.link = 1'b1;
            end
            default: dec.bad = 1'b1;
          endcase
        end
      end
      default: dec.kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/cbj_target.sv
module cbj_target
  import cbj_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [15:0]       hw0,
  input  logic [15:0]       hw1,
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] rx_val,
  input  logic [ADDR_W-1:0] ra_val,
  input  logic [ADDR_W-1:0] test_val,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val,
  output logic              slot_req,
  output logic              illegal
);

  localparam int SHORT_LEN = 2;
  localparam int LONG_LEN  = 4;
  localparam int SLOT_LEN  = 2;
  localparam int ABS_LOW   = 26;

  logic [ADDR_W-1:0] next_short, next_long;
  logic [ADDR_W-1:0] off_near, off_far, abs_tgt;
  logic              cond_src_zero;

  assign next_short = pc + ADDR_W'(SHORT_LEN);
  assign next_long  = pc + ADDR_W'(LONG_LEN);
  assign off_near   = {{(ADDR_W-10){hw0[7]}}, hw0[7:0], 2'b00};
  assign off_far    = {{(ADDR_W-12){hw0[10]}}, hw0[10:0], 1'b0};
  assign abs_tgt    = {next_long[ADDR_W-1:ABS_LOW], hw0[4:0], hw0[9:5], hw1[15:1],
                       hw1[0] ^ dec.xchg};

  always_comb begin
    cond_src_zero = 1'b0;
    taken    = 1'b0;
    target   = next_short;
    link_we  = 1'b0;
    link_val = '0;
    slot_req = 1'b0;
    illegal  = dec.bad;
    case (dec.kind)
      K_BR_REG, K_BR_TEST: begin
        cond_src_zero = (dec.kind == K_BR_REG) ? (rx_val == '0) : (test_val == '0);
        taken  = (cond_src_zero == dec.want_zero);
        target = next_short + off_near;
      end
      K_BR_ALWAYS: begin
        taken  = 1'b1;
        target = next_short + off_far;
      end
      K_JMP_ABS: begin
        taken    = 1'b1;
        target   = abs_tgt;
        slot_req = 1'b1;
        link_we  = dec.link;
        link_val = next_long + ADDR_W'(SLOT_LEN);
      end
      K_JMP_REG: begin
        taken    = 1'b1;
        target   = dec.from_ra ? ra_val : rx_val;
        slot_req = 1'b1;
        link_we  = dec.link;
        link_val = next_short + ADDR_W'(SLOT_LEN);
      end
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbj_slot.sv
module cbj_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              jump_now,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] base
);

  logic              pending;
  logic [ADDR_W-1:0] jump_pc;

  assign base = pending ? jump_pc : pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      jump_pc <= '0;
    end else if (step) begin
      pending <= jump_now;
      jump_pc <= pc;
    end
  end

endmodule

// File: rtl/cbj_unit.sv
module cbj_unit
  import cbj_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [15:0]       hw_first,
  input  logic [15:0]       hw_second,
  input  logic [ADDR_W-1:0] rx_val,
  input  logic [ADDR_W-1:0] ra_val,
  input  logic [ADDR_W-1:0] test_val,
  output logic              res_valid,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val,
  output logic              slot_req,
  output logic [ADDR_W-1:0] slot_base,
  output logic              illegal
);

  dec_t              dec;
  logic              c_taken, c_link_we, c_slot, c_illegal;
  logic [ADDR_W-1:0] c_target, c_link_val, c_base;

  cbj_decode u_decode (
    .hw0 (hw_first),
    .dec (dec)
  );

  cbj_target #(.ADDR_W(ADDR_W)) u_target (
    .pc       (pc_in),
    .hw0      (hw_first),
    .hw1      (hw_second),
    .dec      (dec),
    .rx_val   (rx_val),
    .ra_val   (ra_val),
    .test_val (test_val),
    .taken    (c_taken),
    .target   (c_target),
    .link_we  (c_link_we),
    .link_val (c_link_val),
    .slot_req (c_slot),
    .illegal  (c_illegal)
  );

  cbj_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .step     (in_valid),
    .jump_now (c_slot),
    .pc       (pc_in),
    .base     (c_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      br_taken  <= 1'b0;
      link_we   <= 1'b0;
      slot_req  <= 1'b0;
      illegal   <= 1'b0;
      br_target <= '0;
      link_val  <= '0;
      slot_base <= '0;
    end else begin
      res_valid <= in_valid;
      br_taken  <= in_valid & c_taken;
      link_we   <= in_valid & c_link_we;
      slot_req  <= in_valid & c_slot;
      illegal   <= in_valid & c_illegal;
      if (in_valid) begin
        br_target <= c_target;
        link_val  <= c_link_val;
        slot_base <= c_base;
      end
    end
  end

endmodule

// File: rtl/cbj_unit_chk.sv
module cbj_unit_chk (
  input logic clk,
  input logic rst,
  input logic res_valid,
  input logic br_taken,
  input logic link_we,
  input logic slot_req,
  input logic illegal
);

  // R11
  illegal_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !br_taken && !slot_req && !link_we);

  // R9
  slot_needs_taken_chk: assert property (@(posedge clk) disable iff (rst)
    slot_req |-> br_taken);

  // R8
  link_needs_jump_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> slot_req);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !br_taken && !slot_req && !link_we && !illegal);

endmodule

bind cbj_unit cbj_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .res_valid (res_valid),
  .br_taken  (br_taken),
  .link_we   (link_we),
  .slot_req  (slot_req),
  .illegal   (illegal)
);

// File: tb/cbj_unit_bench.sv
module cbj_unit_bench;

  typedef struct packed {
    logic        taken;
    logic [31:0] target;
    logic        lwe;
    logic [31:0] lval;
    logic        slot;
    logic [31:0] base;
    logic        ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] pc_in = '0;
  logic [15:0] hw_first = '0;
  logic [15:0] hw_second = '0;
  logic [31:0] rx_val = '0;
  logic [31:0] ra_val = '0;
  logic [31:0] test_val = '0;
  logic        res_valid, br_taken, link_we, slot_req, illegal;
  logic [31:0] br_target, link_val, slot_base;

  int   n_chk = 0;
  int   n_fail = 0;
  int   n_issued = 0;
  int   n_seen = 0;
  exp_t exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cbj_unit u_cbj_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pc_in(pc_in),
    .hw_first(hw_first), .hw_second(hw_second), .rx_val(rx_val),
    .ra_val(ra_val), .test_val(test_val), .res_valid(res_valid),
    .br_taken(br_taken), .br_target(br_target), .link_we(link_we),
    .link_val(link_val), .slot_req(slot_req), .slot_base(slot_base),
    .illegal(illegal)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  function automatic exp_t mk(input logic t, input logic [31:0] tg, input logic lw,
                              input logic [31:0] lv, input logic s,
                              input logic [31:0] b, input logic il);
    exp_t e;
    e.taken = t; e.target = tg; e.lwe = lw; e.lval = lv;
    e.slot = s; e.base = b; e.ill = il;
    return e;
  endfunction

  task automatic issue(input logic [31:0] pc, input logic [15:0] h0, input logic [15:0] h1,
                       input logic [31:0] rx, input logic [31:0] ra, input logic [31:0] tv,
                       input exp_t e, input string tag);
    @(negedge clk);
    in_valid = 1'b1; pc_in = pc; hw_first = h0; hw_second = h1;
    rx_val = rx; ra_val = ra; test_val = tv;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    n_issued++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12: actual unexpected result expected none");
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " taken"}, 32'(br_taken), 32'(e.taken));
        if (e.taken) chk({t, " target"}, br_target, e.target);
        chk({t, " link_we"}, 32'(link_we), 32'(e.lwe));
        if (e.lwe) chk({t, " link_val"}, link_val, e.lval);
        chk({t, " slot_req"}, 32'(slot_req), 32'(e.slot));
        chk({t, " base"}, slot_base, e.base);
        chk({t, " illegal"}, 32'(illegal), 32'(e.ill));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    chk("R1 taken", 32'(br_taken), 32'd0);
    chk("R1 slot_req", 32'(slot_req), 32'd0);
    chk("R1 link_we", 32'(link_we), 32'd0);
    chk("R1 illegal", 32'(illegal), 32'd0);
    rst = 1'b0;
    idle(2);
    // R2
    issue(32'h1000, 16'h21FE, 16'h0, 32'd0, 32'd0, 32'd0,
          mk(1, 32'h0FFA, 0, 0, 0, 32'h1000, 0), "R2 eqz taken");
    issue(32'h1000, 16'h21FE, 16'h0, 32'd5, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h1000, 0), "R2 eqz not taken");
    issue(32'h2000, 16'h2910, 16'h0, 32'd7, 32'd0, 32'd0,
          mk(1, 32'h2042, 0, 0, 0, 32'h2000, 0), "R2 nez taken");
    // R3
    issue(32'h3000, 16'h6003, 16'h0, 32'd1, 32'd0, 32'd0,
          mk(1, 32'h300E, 0, 0, 0, 32'h3000, 0), "R3 test zero");
    issue(32'h3000, 16'h6103, 16'h0, 32'd0, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h3000, 0), "R3 test nez not taken");
    issue(32'h3000, 16'h6103, 16'h0, 32'd0, 32'd0, 32'd9,
          mk(1, 32'h300E, 0, 0, 0, 32'h3000, 0), "R3 test nez taken");
    // R13
    issue(32'h3100, 16'h6203, 16'h0, 32'd0, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h3100, 0), "R13 group other");
    // R4
    issue(32'h4000, 16'h17FF, 16'h0, 32'd3, 32'd0, 32'd3,
          mk(1, 32'h4000, 0, 0, 0, 32'h4000, 0), "R4 back one");
    issue(32'h5000, 16'h1400, 16'h0, 32'd3, 32'd0, 32'd3,
          mk(1, 32'h4802, 0, 0, 0, 32'h5000, 0), "R4 far back");
    // R5 R8 R9
    issue(32'hFC00_0100, 16'h1AAA, 16'h1234, 32'd0, 32'd0, 32'd0,
          mk(1, 32'hFD55_1234, 1, 32'hFC00_0106, 1, 32'hFC00_0100, 0), "R5 abs jump");
    // R10 slot instruction
    issue(32'hFC00_0102, 16'h21FE, 16'h0, 32'd1, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'hFC00_0100, 0), "R10 slot base");
    // R6
    issue(32'h0000_0200, 16'h1EAA, 16'h1234, 32'd0, 32'd0, 32'd0,
          mk(1, 32'h0155_1235, 1, 32'h0000_0206, 1, 32'h200, 0), "R6 exchange");
    issue(32'h202, 16'h0000, 16'h0, 32'd0, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h200, 0), "R10 slot after exchange");
    issue(32'h300, 16'h0000, 16'h0, 32'd0, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h300, 0), "R10 own base");
    // R7 chain
    issue(32'h400, 16'hEA00, 16'h0, 32'h8000_0040, 32'd0, 32'd0,
          mk(1, 32'h8000_0040, 0, 0, 1, 32'h400, 0), "R7 jump rx");
    issue(32'h402, 16'hE820, 16'h0, 32'd0, 32'h1234_5678, 32'd0,
          mk(1, 32'h1234_5678, 0, 0, 1, 32'h400, 0), "R7 jump ra");
    issue(32'h404, 16'hEA40, 16'h0, 32'h0000_9000, 32'd0, 32'd0,
          mk(1, 32'h9000, 1, 32'h408, 1, 32'h402, 0), "R8 jump link");
    // R11
    issue(32'h406, 16'hEA60, 16'h0, 32'd4, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h404, 1), "R11 variant 3");
    issue(32'h500, 16'hEAE0, 16'h0, 32'd4, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h500, 1), "R11 variant 7");
    issue(32'h502, 16'hEA01, 16'h0, 32'd4, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h502, 0), "R13 regreg func");
    idle(4);
    // R10 pending across idle
    issue(32'h600, 16'hEA00, 16'h0, 32'h700, 32'd0, 32'd0,
          mk(1, 32'h700, 0, 0, 1, 32'h600, 0), "R9 jump before idle");
    idle(3);
    issue(32'h602, 16'h0000, 16'h0, 32'd0, 32'd0, 32'd0,
          mk(0, 0, 0, 0, 0, 32'h600, 0), "R10 slot after idle");
    idle(4);
    // R12: one result per instruction
    chk("R12 result count", 32'(n_seen), 32'(n_issued));
    chk("R12 queue drained", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule